// File: doc/BRIEF.md
# Configuration Serial Slave

This block is the host-facing configuration port of a filter engine. A host selects it with an active-low chip select. The host then clocks in one command over a serial clock and a data input. The block answers reads over a data output, which a pad wrapper tri-states through a separate enable. Behind the port sit two address spaces:
- a small file of byte-wide control registers, two of which are fixed identification bytes;
- a memory of 32-bit coefficient words.

All port inputs are brought into the system clock domain through a synchronizer and edge detector, so the serial clock must run well below the system clock.

Every transaction starts with an opcode byte, and that byte selects the space and the direction:
- A register command carries one address byte and one data byte.
- A coefficient command carries two address bytes and four data bytes.
- All fields travel most significant bit first.

A bit in the data-configuration register sets which serial clock edge samples the input. The output is launched on the other edge.

A run bit in the control register puts the block into data mode. While the block is in data mode, it honours only a write to the control register itself.

Top module: `cfg_serial_slave`

## Requirements
- R1: Opcode 82h writes a register and 83h reads one: opcode, address byte, data byte. Opcode 86h writes a coefficient word and 87h reads one: opcode, high address byte, low address byte, four data bytes. Every field is sent MSB first.
- R2: While cs_n is high, sdi has no effect and sdo_oe is 0. Releasing cs_n ends any transaction.
- R3: Bit 0 of register 04h selects the capture edge of sdi: 1 for rising, 0 for falling. sdo changes only on the other edge. A new setting applies from the next cs_n assertion.
- R4: Register 00h always reads C0h and register 01h always reads 01h. Writes to either are ignored.
- R5: After reset, register 04h reads 01h (rising capture) and every other writable register reads 00h.
- R6: A coefficient word written at one address reads back whole at that address without disturbing other addresses, including the lowest (000h) and the highest (1FFh).
- R7: Bit 0 of register 03h is the run bit. While it is 1, a register write to 03h is the only command that takes effect. Other writes change nothing, and reads leave sdo_oe at 0.
- R8: An opcode other than 82h, 83h, 86h or 87h makes the rest of the transaction have no effect, and sdo_oe stays 0.
- R9: If cs_n rises before a write's last data bit, nothing is written: neither a register byte nor a coefficient word.
- R10: Register addresses 10h and above, and coefficient addresses 200h and above, are ignored on write and read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host |
| sdo_oe | output | 1 | Drive enable for the sdo pad |

## Verification
Register traffic uses distinct values (A5h, 3Ch, 77h), so a wrong address decode or a bit-order swap shows up on read-back. Coefficient words at both ends of the memory catch crossed or truncated high address bits, and a write at 200h shows whether out-of-range addresses alias into entry 000h.

In each edge mode, the bench makes sdi valid only around the intended capture edge and drives a false value around the other edge, so a block that samples on the wrong edge returns corrupt data. Truncated writes, an undefined opcode, traffic while deselected, and commands in data mode are each followed by a read-back that exposes any state they wrongly changed.

// File: rtl/cfg_slave_pkg.sv
package cfg_slave_pkg;

  localparam logic [7:0] OPC_REG_WRITE  = 8'h82;
  localparam logic [7:0] OPC_REG_READ   = 8'h83;
  localparam logic [7:0] OPC_COEF_WRITE = 8'h86;
  localparam logic [7:0] OPC_COEF_READ  = 8'h87;

  localparam logic [7:0] RADDR_ID   = 8'h00;
  localparam logic [7:0] RADDR_VER  = 8'h01;
  localparam logic [7:0] RADDR_CTRL = 8'h03;
  localparam logic [7:0] RADDR_DCFG = 8'h04;

  localparam logic [7:0] ID_CODE    = 8'hC0;
  localparam logic [7:0] VER_CODE   = 8'h01;
  localparam logic [7:0] DCFG_RESET = 8'h01;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_AHI, ST_ALO, ST_DATA, ST_SKIP
  } link_state_t;

  function automatic logic op_known(input logic [7:0] op);
    return (op == OPC_REG_WRITE) || (op == OPC_REG_READ) ||
           (op == OPC_COEF_WRITE) || (op == OPC_COEF_READ);
  endfunction

  // bit 2 separates the coefficient space, bit 0 the read direction
  function automatic logic op_is_coef(input logic [7:0] op);
    return op[2];
  endfunction

  function automatic logic op_is_read(input logic [7:0] op);
    return op[0];
  endfunction

  function automatic logic reg_is_fixed(input logic [7:0] a);
    return (a == RADDR_ID) || (a == RADDR_VER);
  endfunction

  function automatic logic [7:0] reg_fixed_value(input logic [7:0] a);
    return (a == RADDR_ID) ? ID_CODE : VER_CODE;
  endfunction

  function automatic logic [7:0] reg_reset_value(input logic [7:0] a);
    return (a == RADDR_DCFG) ? DCFG_RESET : 8'h00;
  endfunction

  // in data mode only a register write to the control byte passes
  function automatic logic cmd_allowed(input logic run, input logic is_coef,
                                       input logic is_read, input logic [15:0] a);
    return !run || (!is_coef && !is_read && a == {8'h00, RADDR_CTRL});
  endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_d
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= {STAGES{RST_VAL}};
      q_d  <= RST_VAL;
    end else begin
      pipe[0] <= din;
      for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
      q_d <= pipe[STAGES-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile import cfg_slave_pkg::*; #(
  parameter int NUM_REGS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       run_mode,
  output logic       cap_rise
);

  localparam int         RA_W      = $clog2(NUM_REGS);
  localparam logic [7:0] LAST_ADDR = 8'(NUM_REGS - 1);

  logic [7:0] regs [NUM_REGS];
  logic       wr_hit, rd_hit;

  assign wr_hit = wr_en && (wr_addr <= LAST_ADDR) && !reg_is_fixed(wr_addr);
  assign rd_hit = (rd_addr <= LAST_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= reg_reset_value(8'(i));
    end else if (wr_hit) begin
      regs[wr_addr[RA_W-1:0]] <= wr_data;
    end
  end

  always_comb begin
    if (!rd_hit)                rd_data = 8'h00;
    else if (reg_is_fixed(rd_addr)) rd_data = reg_fixed_value(rd_addr);
    else                        rd_data = regs[rd_addr[RA_W-1:0]];
  end

  assign run_mode = regs[RADDR_CTRL[RA_W-1:0]][0];
  assign cap_rise = regs[RADDR_DCFG[RA_W-1:0]][0];

endmodule

// File: rtl/cfg_coef_ram.sv
module cfg_coef_ram #(
  parameter int AW    = 9,
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave import cfg_slave_pkg::*; #(
  parameter int NUM_REGS = 16,
  parameter int COEF_AW  = 9,
  parameter int COEF_W   = 32,
  parameter int SYNC_STG = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic sdi,
  output logic sdo,
  output logic sdo_oe
);

  localparam int                NBYTES    = COEF_W / 8;
  localparam int                BC_W      = $clog2(NBYTES);
  localparam logic [BC_W-1:0]   LAST_BYTE = BC_W'(NBYTES - 1);

  function automatic logic coef_addr_ok(input logic [15:0] a);
    return (a >> COEF_AW) == 16'h0000;
  endfunction

  // ---- input synchronisation and edge events ----
  logic [2:0] sync_q, sync_d;
  cfg_sync #(.WIDTH(3), .STAGES(SYNC_STG), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({cs_n, sck, sdi}), .q(sync_q), .q_d(sync_d)
  );

  logic cs_s, cs_fall_evt, sck_rise, sck_fall, sdi_s;
  assign cs_s        = sync_q[2];
  assign cs_fall_evt = sync_d[2] & ~sync_q[2];
  assign sck_rise    = sync_q[1] & ~sync_d[1];
  assign sck_fall    = ~sync_q[1] & sync_d[1];
  assign sdi_s       = sync_d[0];

  logic pol_q;
  logic cap_evt, launch_evt;
  assign cap_evt    = ~cs_s & (pol_q ? sck_rise : sck_fall);
  assign launch_evt = ~cs_s & (pol_q ? sck_fall : sck_rise);

  // ---- link state ----
  link_state_t          state;
  logic [2:0]           bit_cnt;
  logic [6:0]           sh_in;
  logic                 is_coef_q, is_read_q;
  logic [15:0]          addr_q;
  logic [BC_W-1:0]      byte_cnt;
  logic [COEF_W-9:0]    wacc;
  logic [COEF_W-1:0]    rd_sh;
  logic                 sdo_q, oe_q;

  logic                 rx_state, byte_done;
  logic [7:0]           rx_byte;
  logic [15:0]          addr_now;
  logic                 cmd_ok;
  logic                 reg_wr_fire, coef_wr_fire, coef_we;
  logic [7:0]           reg_rdata;
  logic [COEF_W-1:0]    coef_rdata, read_word;
  logic                 run_mode, cap_rise;

  assign rx_state  = (state == ST_OPC) || (state == ST_AHI) ||
                     (state == ST_ALO) || (state == ST_DATA);
  assign byte_done = cap_evt && rx_state && (bit_cnt == 3'd7);
  assign rx_byte   = {sh_in, sdi_s};
  assign addr_now  = {addr_q[15:8], rx_byte};
  assign cmd_ok    = cmd_allowed(run_mode, is_coef_q, is_read_q, addr_now);

  assign reg_wr_fire  = byte_done && (state == ST_DATA) && !is_read_q && !is_coef_q;
  assign coef_wr_fire = byte_done && (state == ST_DATA) && !is_read_q && is_coef_q &&
                        (byte_cnt == LAST_BYTE);
  assign coef_we      = coef_wr_fire && coef_addr_ok(addr_q);

  assign read_word = is_coef_q ? (coef_addr_ok(addr_now) ? coef_rdata : '0)
                               : {reg_rdata, {(COEF_W-8){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      sh_in     <= '0;
      is_coef_q <= 1'b0;
      is_read_q <= 1'b0;
      addr_q    <= '0;
      byte_cnt  <= '0;
      wacc      <= '0;
      rd_sh     <= '0;
      sdo_q     <= 1'b0;
      oe_q      <= 1'b0;
      pol_q     <= 1'b1;
    end else if (cs_s) begin
      state <= ST_IDLE;
      oe_q  <= 1'b0;
      sdo_q <= 1'b0;
    end else if (cs_fall_evt) begin
      state    <= ST_OPC;
      bit_cnt  <= '0;
      addr_q   <= '0;
      byte_cnt <= '0;
      pol_q    <= cap_rise;
    end else begin
      if (cap_evt && rx_state) begin
        sh_in   <= {sh_in[5:0], sdi_s};
        bit_cnt <= bit_cnt + 3'd1;
      end
      if (byte_done) begin
        unique case (state)
          ST_OPC: begin
            if (op_known(rx_byte)) begin
              is_coef_q <= op_is_coef(rx_byte);
              is_read_q <= op_is_read(rx_byte);
              state     <= op_is_coef(rx_byte) ? ST_AHI : ST_ALO;
            end else begin
              state <= ST_SKIP;
            end
          end
          ST_AHI: begin
            addr_q[15:8] <= rx_byte;
            state        <= ST_ALO;
          end
          ST_ALO: begin
            addr_q[7:0] <= rx_byte;
            if (!cmd_ok) begin
              state <= ST_SKIP;
            end else begin
              state <= ST_DATA;
              if (is_read_q) begin
                rd_sh <= read_word;
                oe_q  <= 1'b1;
              end
            end
          end
          ST_DATA: begin
            if (!is_read_q) begin
              wacc     <= {wacc[COEF_W-17:0], rx_byte};
              byte_cnt <= byte_cnt + BC_W'(1);
              if (!is_coef_q || byte_cnt == LAST_BYTE) state <= ST_SKIP;
            end
          end
          default: ;
        endcase
      end
      if (launch_evt && state == ST_DATA && is_read_q) begin
        sdo_q <= rd_sh[COEF_W-1];
        rd_sh <= {rd_sh[COEF_W-2:0], 1'b0};
      end
    end
  end

  assign sdo    = oe_q & sdo_q;
  assign sdo_oe = oe_q;

  // ---- storage ----
  cfg_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_fire), .wr_addr(addr_q[7:0]), .wr_data(rx_byte),
    .rd_addr(rx_byte), .rd_data(reg_rdata),
    .run_mode(run_mode), .cap_rise(cap_rise)
  );

  cfg_coef_ram #(.AW(COEF_AW), .WIDTH(COEF_W)) u_coef (
    .clk(clk), .we(coef_we), .waddr(addr_q[COEF_AW-1:0]),
    .wdata({wacc, rx_byte}), .raddr(addr_now[COEF_AW-1:0]), .rdata(coef_rdata)
  );

  // ---- assertions ----
  // R2
  idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !sdo_oe);

  // R3
  sdo_launch_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && !launch_evt && !cs_s) |=> $stable(sdo));

  // R7
  run_write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode && reg_wr_fire) |-> (addr_q == {8'h00, RADDR_CTRL}));

  // R7
  run_coef_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_mode |-> !coef_we);

  // R8
  skip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP && !cs_s) |=> (state == ST_SKIP && !sdo_oe));

endmodule

// File: tb/test_cfg_serial_slave.sv
module test_cfg_serial_slave;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic tb_pol = 1'b1;
  logic oe_seen = 1'b0;

  always #5 clk = ~clk;

  cfg_serial_slave i_cfg_serial_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hp(); repeat (8) @(negedge clk); endtask
  task automatic qp(); repeat (4) @(negedge clk); endtask

  // sdi is valid only around the capture edge; a false value surrounds the other edge
  task automatic bit_io(input logic b, output logic r);
    if (tb_pol) begin
      sdi = b; hp(); r = sdo; oe_seen |= sdo_oe;
      sck = 1'b1; qp(); sdi = ~b; qp(); sck = 1'b0;
    end else begin
      sck = 1'b1; qp(); sdi = b; qp(); r = sdo; oe_seen |= sdo_oe;
      sck = 1'b0; hp();
    end
  endtask

  task automatic byte_io(input logic [7:0] b, output logic [7:0] r);
    for (int k = 7; k >= 0; k--) begin
      logic bt;
      bit_io(b[k], bt);
      r[k] = bt;
    end
  endtask

  task automatic tx_begin(); cs_n = 1'b0; oe_seen = 1'b0; hp(); hp(); endtask
  task automatic tx_end();   hp(); cs_n = 1'b1; sdi = 1'b0; hp(); hp(); endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] x;
    tx_begin(); byte_io(8'h82, x); byte_io(a, x); byte_io(d, x); tx_end();
  endtask

  task automatic cfg_rd(input logic [7:0] a, output logic [7:0] d);
    logic [7:0] x;
    tx_begin(); byte_io(8'h83, x); byte_io(a, x); byte_io(8'h00, d); tx_end();
  endtask

  task automatic coef_wr(input logic [15:0] a, input logic [31:0] d);
    logic [7:0] x;
    tx_begin(); byte_io(8'h86, x); byte_io(a[15:8], x); byte_io(a[7:0], x);
    for (int n = 3; n >= 0; n--) byte_io(d[n*8 +: 8], x);
    tx_end();
  endtask

  task automatic coef_rd(input logic [15:0] a, output logic [31:0] d);
    logic [7:0] x, y;
    tx_begin(); byte_io(8'h87, x); byte_io(a[15:8], x); byte_io(a[7:0], x);
    for (int n = 3; n >= 0; n--) begin byte_io(8'h00, y); d[n*8 +: 8] = y; end
    tx_end();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R2 oe after reset", {31'b0, sdo_oe}, 32'h0);
    cfg_rd(8'h04, d); check("R5 reg 04h default", {24'b0, d}, 32'h01);
    cfg_rd(8'h03, d); check("R5 reg 03h default", {24'b0, d}, 32'h00);
    cfg_rd(8'h07, d); check("R5 reg 07h default", {24'b0, d}, 32'h00);
  endtask

  task automatic t_ident();
    logic [7:0] d;
    cfg_rd(8'h00, d); check("R4 id byte", {24'b0, d}, 32'hC0);
    cfg_rd(8'h01, d); check("R4 version byte", {24'b0, d}, 32'h01);
    cfg_wr(8'h00, 8'h55); cfg_wr(8'h01, 8'hAA);
    cfg_rd(8'h00, d); check("R4 id after write", {24'b0, d}, 32'hC0);
    cfg_rd(8'h01, d); check("R4 version after write", {24'b0, d}, 32'h01);
  endtask

  task automatic t_reg_rw();
    logic [7:0] d;
    cfg_wr(8'h05, 8'hA5); cfg_wr(8'h0F, 8'h3C);
    cfg_rd(8'h05, d); check("R1 reg 05h", {24'b0, d}, 32'hA5);
    cfg_rd(8'h0F, d); check("R1 reg 0Fh", {24'b0, d}, 32'h3C);
    check("R1 oe during read", {31'b0, oe_seen}, 32'h1);
  endtask

  task automatic t_coef();
    logic [31:0] w;
    coef_wr(16'h0000, 32'h12345678); coef_wr(16'h01FF, 32'hDEADBEEF);
    coef_rd(16'h0000, w); check("R6 coef 000h", w, 32'h12345678);
    coef_rd(16'h01FF, w); check("R6 coef 1FFh", w, 32'hDEADBEEF);
  endtask

  task automatic t_partial();
    logic [7:0] x, d;
    logic [31:0] w;
    tx_begin(); byte_io(8'h82, x); byte_io(8'h05, x);
    for (int k = 0; k < 5; k++) begin logic bt; bit_io(1'b0, bt); end
    tx_end();
    cfg_rd(8'h05, d); check("R9 partial reg write", {24'b0, d}, 32'hA5);
    tx_begin(); byte_io(8'h86, x); byte_io(8'h00, x); byte_io(8'h00, x);
    byte_io(8'h11, x); byte_io(8'h22, x); byte_io(8'h33, x);
    tx_end();
    coef_rd(16'h0000, w); check("R9 partial coef write", w, 32'h12345678);
  endtask

  task automatic t_bad_opcode();
    logic [7:0] x, d;
    tx_begin(); byte_io(8'h84, x); byte_io(8'h05, x); byte_io(8'h00, x);
    byte_io(8'h00, x); tx_end();
    check("R8 oe on undefined opcode", {31'b0, oe_seen}, 32'h0);
    cfg_rd(8'h05, d); check("R8 reg 05h untouched", {24'b0, d}, 32'hA5);
  endtask

  task automatic t_range();
    logic [7:0] d;
    logic [31:0] w;
    cfg_wr(8'h20, 8'h99);
    cfg_rd(8'h20, d); check("R10 reg 20h reads zero", {24'b0, d}, 32'h00);
    coef_wr(16'h0200, 32'hCAFEF00D);
    coef_rd(16'h0200, w); check("R10 coef 200h reads zero", w, 32'h0);
    coef_rd(16'h0000, w); check("R10 coef 000h not aliased", w, 32'h12345678);
  endtask

  task automatic t_cs_idle();
    logic [7:0] x, d;
    oe_seen = 1'b0;
    byte_io(8'h82, x); byte_io(8'h05, x); byte_io(8'hFF, x);
    hp();
    check("R2 oe while deselected", {31'b0, oe_seen}, 32'h0);
    cfg_rd(8'h05, d); check("R2 reg 05h untouched", {24'b0, d}, 32'hA5);
  endtask

  task automatic t_edge();
    logic [7:0] d;
    cfg_wr(8'h04, 8'h00);
    tb_pol = 1'b0;
    cfg_rd(8'h04, d); check("R3 falling capture, reg 04h", {24'b0, d}, 32'h00);
    cfg_wr(8'h06, 8'h77);
    cfg_rd(8'h06, d); check("R3 falling capture, reg 06h", {24'b0, d}, 32'h77);
    cfg_wr(8'h04, 8'h01);
    tb_pol = 1'b1;
    cfg_rd(8'h06, d); check("R3 rising capture restored", {24'b0, d}, 32'h77);
  endtask

  task automatic t_run_mode();
    logic [7:0] d;
    logic [31:0] w;
    cfg_wr(8'h03, 8'h01);
    cfg_rd(8'h05, d);
    check("R7 read blocked in data mode", {31'b0, oe_seen}, 32'h0);
    cfg_wr(8'h05, 8'h11);
    coef_wr(16'h0000, 32'h0BADC0DE);
    cfg_wr(8'h03, 8'h00);
    cfg_rd(8'h05, d); check("R7 reg write blocked", {24'b0, d}, 32'hA5);
    coef_rd(16'h0000, w); check("R7 coef write blocked", w, 32'h12345678);
    cfg_rd(8'h03, d); check("R7 run bit cleared", {24'b0, d}, 32'h00);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_ident();
    t_reg_rw();
    t_coef();
    t_partial();
    t_bad_opcode();
    t_range();
    t_cs_idle();
    t_edge();
    t_run_mode();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule